// File: doc/BRIEF.md
# Dual-Latch Parallel Output Control Interface

This block is the write port between a microcontroller and a bank of eight output-enable lines. The host presents a byte on the data pins and drives active-low chip select and write strobes. While both strobes are low, a staging latch follows the data pins. When the write strobe rises, the staging latch holds. When chip select later rises, the staged byte moves into the output register that drives the enables. All host pins are asynchronous to the block. They pass through two-flop synchronizers on a fast system clock, and edges are found on the synchronized copies.

An active-low disable input turns every enable off at once, through a combinational path that needs no clock. Its synchronized copy clears both the staging latch and the output register, so the outputs stay off after disable is released until a new write is committed. If the host holds chip select and write low together for a programmable number of clocks, the block enters a transparent direct mode in which the synchronized data pins drive the enables. Disable still wins in direct mode. Leaving disable clears the qualification count, so direct mode has to qualify again.

Top module: `par_out_ctrl`

## Requirements
- R1: Data bit n drives output enable n, for every n from 0 to NCH-1. No bits are swapped or mixed between channels.
- R2: The staging latch loads the data pins only while chip select and write are both low. When write is high or chip select is high, later data changes do not reach the outputs.
- R3: A rising chip select copies the staging latch into the output register. Before that edge, the outputs keep their previous value.
- R4: While disable is low, all output enables are 0 with no clock edge needed. This applies in every mode.
- R5: Disable low clears the staging latch and the output register. After disable returns high, the outputs stay 0 until a write is committed. A chip select pulse with no write then commits 0.
- R6: After chip select and write have both been low for DIRECT_HOLD consecutive synchronized clocks, the outputs follow the synchronized data pins.
- R7: After synchronous reset, the output enables are 0, the staging latch is 0 and direct mode is off.
- R8: In direct mode, disable low forces the outputs to 0 even though the data pins are high.
- R9: If chip select and write are both low for fewer than DIRECT_HOLD clocks, the block stays in latched mode, and data on the pins does not reach the outputs before chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| dis_n | input | 1 | Output disable, active low, asynchronous |
| din | input | NCH | Data pins, bit n for channel n |
| out_en | output | NCH | Output enables, bit n for channel n |

## Verification
The hardest case to reach is the boundary between a long ordinary write and direct mode. The bench holds both strobes low for a few clocks, well below the qualification count, and checks mid-write that the new data has not reached the outputs. It then holds both strobes low past the count and checks that the outputs track the data pins. The behaviour after a disable is reached by pulsing chip select with no write after disable is released, which shows that the staging latch was cleared. A disable asserted during direct mode shows that disable takes priority over the data pins.

// File: rtl/par_out_pkg.sv
package par_out_pkg;
    localparam int NCH_DEF  = 8;
    localparam int HOLD_DEF = 16;

    // synchronized host strobes, one bundle
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic dis_n;
    } strobe_t;

    typedef enum logic {
        MODE_LATCHED = 1'b0,
        MODE_DIRECT  = 1'b1
    } mode_e;

    function automatic logic both_low(input strobe_t s);
        return !s.cs_n && !s.wr_n;
    endfunction
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/latch_ctrl.sv
module latch_ctrl
    import par_out_pkg::*;
#(
    parameter int NCH = NCH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  strobe_t        st,
    input  logic [NCH-1:0] din_s,
    output logic [NCH-1:0] out_q,
    output logic [NCH-1:0] stage_q
);
    logic cs_prev;
    logic cs_rise;

    assign cs_rise = st.cs_n && !cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev <= 1'b1;
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            cs_prev <= st.cs_n;
            if (!st.dis_n) begin
                stage_q <= '0;
                out_q   <= '0;
            end else begin
                if (both_low(st)) stage_q <= din_s;
                if (cs_rise)      out_q   <= stage_q;
            end
        end
    end

    // R5: disable clears both storage stages
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !st.dis_n |=> (out_q == '0 && stage_q == '0));
    // R2: the stage holds unless both strobes are low
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st.dis_n && !both_low(st)) |=> $stable(stage_q));
    // R3: the output changes only on a chip select rise
    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (st.dis_n && !cs_rise) |=> $stable(out_q));
    // R3: a commit copies the staged byte
    p_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (st.dis_n && cs_rise) |=> out_q == $past(stage_q));
endmodule

// File: rtl/direct_detect.sv
module direct_detect
    import par_out_pkg::*;
#(
    parameter int HOLD = HOLD_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t st,
    output mode_e   mode
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !st.dis_n || !both_low(st)) cnt <= '0;
        else if (cnt != LIMIT)                 cnt <= cnt + 1'b1;
    end

    assign mode = (cnt == LIMIT) ? MODE_DIRECT : MODE_LATCHED;

    // R6/R9: direct mode starts only with both strobes low
    p_enter_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == MODE_DIRECT) |-> $past(both_low(st)));
    // R8: disable drops direct mode on the next clock
    p_dis_exit_r8: assert property (@(posedge clk) disable iff (rst)
        !st.dis_n |=> mode == MODE_LATCHED);
endmodule

// File: rtl/par_out_ctrl.sv
module par_out_ctrl
    import par_out_pkg::*;
#(
    parameter int NCH         = NCH_DEF,
    parameter int SYNC_STAGES = 2,
    parameter int DIRECT_HOLD = HOLD_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic           dis_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] out_en
);
    localparam int SW = NCH + 3;
    localparam logic [SW-1:0] SRST = {3'b111, {NCH{1'b0}}};

    logic [SW-1:0]  raw_bus, syn_bus;
    strobe_t        st;
    logic [NCH-1:0] din_s, out_q, stage_q;
    mode_e          mode;

    assign raw_bus = {cs_n, wr_n, dis_n, din};

    sync_bank #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SRST)) u_sync (
        .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
    );

    assign st    = strobe_t'(syn_bus[SW-1 -: 3]);
    assign din_s = syn_bus[NCH-1:0];

    latch_ctrl #(.NCH(NCH)) u_latch (
        .clk(clk), .rst(rst), .st(st), .din_s(din_s),
        .out_q(out_q), .stage_q(stage_q)
    );

    direct_detect #(.HOLD(DIRECT_HOLD)) u_direct (
        .clk(clk), .rst(rst), .st(st), .mode(mode)
    );

    // raw disable gates the enables with no clock in the path
    always_comb begin
        if (!dis_n)                   out_en = '0;
        else if (mode == MODE_DIRECT) out_en = din_s;
        else                          out_en = out_q;
    end

    // R7: reset leaves the stage empty and the mode latched
    p_reset_r7: assert property (@(posedge clk)
        $past(rst) |-> (stage_q == '0 && out_q == '0 && mode == MODE_LATCHED));
endmodule

// File: tb/tb_par_out_ctrl.sv
module tb_par_out_ctrl;
    localparam int NCH  = 8;
    localparam int HOLD = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cs_n = 1'b1, wr_n = 1'b1, dis_n = 1'b1;
    logic [NCH-1:0] din = '0;
    logic [NCH-1:0] out_en;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct { logic [NCH-1:0] exp; string tag; } item_t;
    item_t q[$];

    always #10 clk = ~clk;

    par_out_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .DIRECT_HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .dis_n(dis_n),
        .din(din), .out_en(out_en)
    );

    task automatic check(input logic [NCH-1:0] exp, input string tag);
        n_chk++;
        if (out_en !== exp) begin
            n_bad++;
            $display("FAIL %s: out_en=%h expected=%h", tag, out_en, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: queue an expectation, wait for the monitor
    task automatic expect_out(input logic [NCH-1:0] e, input string tag);
        q.push_back('{e, tag});
        wait (q.size() == 0);
    endtask

    task automatic do_write(input logic [NCH-1:0] d);
        cs_n = 1'b0; cyc(1);
        din = d; wr_n = 1'b0; cyc(3);
        wr_n = 1'b1; cyc(2);
        din = ~d; cyc(2);
        cs_n = 1'b1; cyc(1);
    endtask

    // monitor: settle, sample away from the edge, compare
    initial begin
        forever begin
            wait (q.size() > 0);
            cyc(6);
            #2;
            begin
                item_t it;
                it = q.pop_front();
                check(it.exp, it.tag);
            end
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check('0, "R7 reset");

        do_write(8'h01); expect_out(8'h01, "R1 bit0");
        do_write(8'h80); expect_out(8'h80, "R1 bit7");
        do_write(8'hA5); expect_out(8'hA5, "R1 R2 R3 write A5");

        // R3: staged but not committed
        cs_n = 1'b0; din = 8'h3C; wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(6); #2;
        check(8'hA5, "R3 before cs rise");
        din = 8'hFF; cyc(4);
        cs_n = 1'b1; expect_out(8'h3C, "R2 data after wr ignored");

        // R2: write strobe with chip select high does not load
        wr_n = 1'b0; din = 8'hEE; cyc(3); wr_n = 1'b1; cyc(2);
        cs_n = 1'b0; cyc(3); cs_n = 1'b1;
        expect_out(8'h3C, "R2 wr without cs");

        // R9: short write, mid-write outputs keep old value
        cs_n = 1'b0; din = 8'h66; wr_n = 1'b0; cyc(6); #2;
        check(8'h3C, "R9 no direct mid-write");
        wr_n = 1'b1; cyc(2); cs_n = 1'b1;
        expect_out(8'h66, "R9 write commits");

        // R4: disable acts at once
        dis_n = 1'b0; #1;
        check('0, "R4 immediate off");
        cyc(4);
        dis_n = 1'b1;
        expect_out('0, "R5 off after release");
        cs_n = 1'b0; cyc(3); cs_n = 1'b1;
        expect_out('0, "R5 stage cleared");
        do_write(8'h81); expect_out(8'h81, "R5 new write");

        // R6: direct mode
        cs_n = 1'b0; wr_n = 1'b0; din = 8'h5A; cyc(HOLD + 6);
        expect_out(8'h5A, "R6 direct 5A");
        din = 8'h0F; expect_out(8'h0F, "R6 direct 0F");

        // R8: disable beats direct data
        din = 8'hFF; cyc(4);
        dis_n = 1'b0; #1;
        check('0, "R8 disable in direct");
        cyc(4); #2;
        check('0, "R8 held off");
        dis_n = 1'b1; cyc(HOLD + 4);
        expect_out(8'hFF, "R6 requalify");

        wr_n = 1'b1; cyc(2); cs_n = 1'b1;
        expect_out(8'hFF, "R3 exit direct commits");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: out_en=%h expected=done", out_en);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule